// File: doc/BRIEF.md
# Power-Link Packet Receiver Checker

This block sits behind the demodulator of an inductive power link and turns a stream of received bytes into checked packets. Once told that a preamble has been found, it takes one field per byte strobe, each field arriving with its own parity bit. The fields arrive in a fixed order: a header, two message fields, then a trailing checksum. It checks the odd parity of every field. It also checks that the checksum equals the bitwise XOR of the header and both message fields.

A packet that passes both checks gives a one-cycle valid pulse. The header and message outputs are refreshed with that pulse and keep their values until the next good packet. A flag tells whether the header falls in the low range reserved for periodic power-control reports. Any failure gives a one-cycle error pulse with a cause code and the index of the field concerned. A failure drops the packet and sends the block back to waiting for a preamble. A gap between strobes that lasts too long is also a failure.

Top module: `pkt_rx_checker`

## Requirements
- R1: After reset, `pkt_vld_o`, `err_o` and `pwr_ctl_o` are 0, and `hdr_o`, `msg1_o`, `msg2_o`, `err_cause_o` and `err_field_o` are all zero.
- R2: When a packet is correct, `pkt_vld_o` is high for exactly one cycle. That cycle follows the clock edge that takes the checksum strobe. In it, `hdr_o`, `msg1_o` and `msg2_o` show the received header and message fields.
- R3: A field's parity is correct when the field bits plus its parity bit hold an odd number of ones. A field with bad parity raises `err_o` for one cycle after its strobe. `err_cause_o` is then 1, and `err_field_o` gives the field index: 0 header, 1 message 1, 2 message 2, 3 checksum. A parity error on the checksum field takes precedence over a mismatch.
- R4: A checksum field with good parity that differs from the XOR of the header and both messages raises `err_o` with `err_cause_o` = 2 and `err_field_o` = 3, and no valid pulse.
- R5: While a packet is being collected, GAP_MAX idle cycles in a row after the preamble or the last strobe are allowed. The next idle cycle raises `err_o` with `err_cause_o` = 3, and `err_field_o` gives the index of the field still expected.
- R6: After any error, strobes are ignored until the next preamble: no pulse occurs and the outputs stay unchanged.
- R7: The header, message and flag outputs change only with a valid pulse. `err_cause_o` and `err_field_o` change only with an error pulse.
- R8: With each valid pulse, `pwr_ctl_o` is 1 when the header is at most PWR_HDR_MAX (default 0x0F) and 0 otherwise.
- R9: A preamble that arrives in the middle of a packet restarts collection at the header without an error, and the fresh packet is checked normally.
- R10: Strobes that arrive before any preamble are ignored.
- R11: `pkt_vld_o` and `err_o` are never high in the same cycle, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_found_i | input | 1 | Preamble detected; starts or restarts a packet |
| byte_vld_i | input | 1 | Strobe for one received field |
| byte_i | input | FIELD_W | Received field bits |
| par_i | input | 1 | Received parity bit of the field |
| hdr_o | output | FIELD_W | Header of the last good packet |
| msg1_o | output | FIELD_W | Message 1 of the last good packet |
| msg2_o | output | FIELD_W | Message 2 of the last good packet |
| pwr_ctl_o | output | 1 | Last good header is in the power-control range |
| pkt_vld_o | output | 1 | One-cycle pulse for a good packet |
| err_o | output | 1 | One-cycle pulse for a dropped packet |
| err_cause_o | output | 2 | 1 parity, 2 checksum, 3 gap timeout |
| err_field_o | output | 2 | Field index that caused the last error |

## Verification
The assertions rely on the demodulator delivering strobes as single-cycle events and on a preamble never arriving together with the strobe it starts. Under those conditions a packet needs at least four cycles after its preamble, so pulses cannot follow each other back to back. The stimulus drives every input at the falling edge, gives each strobe exactly one cycle, and raises the preamble alone. Random gaps stay within GAP_MAX, except in the cases chosen to check the timeout.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_PARITY = 2'd1,
    CAUSE_CKSUM  = 2'd2,
    CAUSE_GAP    = 2'd3
  } cause_e;

  typedef enum logic {
    ST_WAIT    = 1'b0,
    ST_COLLECT = 1'b1
  } rx_st_e;

  localparam int unsigned NUM_MSG    = 2;
  localparam int unsigned NUM_FIELDS = NUM_MSG + 2;
endpackage

// File: rtl/pkt_parity_chk.sv
module pkt_parity_chk #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic         par_i,
  output logic         ok_o
);
  // odd parity over data plus parity bit
  assign ok_o = ^{data_i, par_i};
endmodule

// File: rtl/pkt_xor_acc.sv
module pkt_xor_acc #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (en_i)  acc_o <= acc_o ^ data_i;
  end
endmodule

// File: rtl/pkt_gap_timer.sv
module pkt_gap_timer #(
  parameter int unsigned GAP_MAX = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic idle_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = $clog2(GAP_MAX + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = idle_i && (cnt_q == CNT_W'(GAP_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i)          cnt_q <= '0;
    else if (idle_i && !expire_o) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/pkt_rx_checker.sv
module pkt_rx_checker
  import pkt_rx_pkg::*;
#(
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned GAP_MAX     = 64,
  parameter int unsigned PWR_HDR_MAX = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pre_found_i,
  input  logic               byte_vld_i,
  input  logic [FIELD_W-1:0] byte_i,
  input  logic               par_i,
  output logic [FIELD_W-1:0] hdr_o,
  output logic [FIELD_W-1:0] msg1_o,
  output logic [FIELD_W-1:0] msg2_o,
  output logic               pwr_ctl_o,
  output logic               pkt_vld_o,
  output logic               err_o,
  output logic [1:0]         err_cause_o,
  output logic [1:0]         err_field_o
);
  localparam int unsigned IDX_W  = $clog2(NUM_FIELDS);
  localparam int unsigned DATA_N = NUM_FIELDS - 1;

  rx_st_e             st_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FIELD_W-1:0] fld_q [DATA_N];
  logic [FIELD_W-1:0] acc;
  logic               par_ok, accept, last, ck_ok, expire, idle, collecting;

  assign collecting = (st_q == ST_COLLECT);
  assign accept     = collecting && byte_vld_i && !pre_found_i;
  assign idle       = collecting && !byte_vld_i && !pre_found_i;
  assign last       = (idx_q == IDX_W'(NUM_FIELDS - 1));
  assign ck_ok      = (byte_i == acc);

  pkt_parity_chk #(.W(FIELD_W)) u_par (
    .data_i (byte_i),
    .par_i  (par_i),
    .ok_o   (par_ok)
  );

  pkt_xor_acc #(.W(FIELD_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pre_found_i),
    .en_i   (accept && par_ok && !last),
    .data_i (byte_i),
    .acc_o  (acc)
  );

  pkt_gap_timer #(.GAP_MAX(GAP_MAX)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (pre_found_i || accept || !collecting),
    .idle_i    (idle),
    .expire_o  (expire)
  );

  // field capture, one register per data field
  for (genvar g = 0; g < DATA_N; g++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        fld_q[g] <= '0;
      else if (accept && par_ok && idx_q == IDX_W'(g))
        fld_q[g] <= byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_WAIT;
      idx_q       <= '0;
      pkt_vld_o   <= 1'b0;
      err_o       <= 1'b0;
      err_cause_o <= CAUSE_NONE;
      err_field_o <= '0;
      hdr_o       <= '0;
      msg1_o      <= '0;
      msg2_o      <= '0;
      pwr_ctl_o   <= 1'b0;
    end else begin
      pkt_vld_o <= 1'b0;
      err_o     <= 1'b0;
      if (pre_found_i) begin
        st_q  <= ST_COLLECT;
        idx_q <= '0;
      end else if (accept) begin
        if (!par_ok) begin
          st_q        <= ST_WAIT;
          err_o       <= 1'b1;
          err_cause_o <= CAUSE_PARITY;
          err_field_o <= idx_q;
        end else if (last) begin
          st_q <= ST_WAIT;
          if (ck_ok) begin
            pkt_vld_o <= 1'b1;
            hdr_o     <= fld_q[0];
            msg1_o    <= fld_q[1];
            msg2_o    <= fld_q[2];
            pwr_ctl_o <= (fld_q[0] <= FIELD_W'(PWR_HDR_MAX));
          end else begin
            err_o       <= 1'b1;
            err_cause_o <= CAUSE_CKSUM;
            err_field_o <= idx_q;
          end
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end else if (expire) begin
        st_q        <= ST_WAIT;
        err_o       <= 1'b1;
        err_cause_o <= CAUSE_GAP;
        err_field_o <= idx_q;
      end
    end
  end
endmodule

// File: rtl/pkt_rx_checker_sva.sv
module pkt_rx_checker_sva #(
  parameter int unsigned FIELD_W     = 8,
  parameter int unsigned PWR_HDR_MAX = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pre_found_i,
  input logic               byte_vld_i,
  input logic [FIELD_W-1:0] hdr_o,
  input logic               pwr_ctl_o,
  input logic               pkt_vld_o,
  input logic               err_o,
  input logic [1:0]         err_cause_o,
  input logic [1:0]         err_field_o
);
  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_vld_o && err_o));

  p_vld_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_o |=> !pkt_vld_o);

  p_err_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_vld_after_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_o |-> $past(byte_vld_i));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_vld_o |-> ($stable(hdr_o) && $stable(pwr_ctl_o)));

  p_err_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> ($stable(err_cause_o) && $stable(err_field_o)));

  p_cause_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_cause_o != 2'd0));

  p_cksum_field_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && err_cause_o == 2'd2) |-> (err_field_o == 2'd3));

  p_gap_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && err_cause_o == 2'd3) |-> $past(!byte_vld_i));

  p_pwr_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_o |-> (pwr_ctl_o == (hdr_o <= FIELD_W'(PWR_HDR_MAX))));

  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_found_i |=> !pkt_vld_o);
endmodule

bind pkt_rx_checker pkt_rx_checker_sva #(
  .FIELD_W     (FIELD_W),
  .PWR_HDR_MAX (PWR_HDR_MAX)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pre_found_i (pre_found_i),
  .byte_vld_i  (byte_vld_i),
  .hdr_o       (hdr_o),
  .pwr_ctl_o   (pwr_ctl_o),
  .pkt_vld_o   (pkt_vld_o),
  .err_o       (err_o),
  .err_cause_o (err_cause_o),
  .err_field_o (err_field_o)
);

// File: tb/pkt_rx_checker_bench.sv
module pkt_rx_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int GAP        = 6;
  localparam int PWR_MAX    = 15;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         pre_found_i = 1'b0;
  logic         byte_vld_i = 1'b0;
  logic [W-1:0] byte_i = '0;
  logic         par_i = 1'b0;
  logic [W-1:0] hdr_o, msg1_o, msg2_o;
  logic         pwr_ctl_o, pkt_vld_o, err_o;
  logic [1:0]   err_cause_o, err_field_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [W-1:0] e_hdr = '0, e_m1 = '0, e_m2 = '0;
  logic         e_pwr = 1'b0;
  logic [1:0]   e_cause = '0, e_field = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_rx_checker #(.FIELD_W(W), .GAP_MAX(GAP), .PWR_HDR_MAX(PWR_MAX)) u_pkt_rx_checker (
    .clk_i(clk), .rst_ni(rst_ni), .pre_found_i(pre_found_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .par_i(par_i), .hdr_o(hdr_o), .msg1_o(msg1_o), .msg2_o(msg2_o),
    .pwr_ctl_o(pwr_ctl_o), .pkt_vld_o(pkt_vld_o), .err_o(err_o),
    .err_cause_o(err_cause_o), .err_field_o(err_field_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic odd_par(input logic [W-1:0] d);
    return ~^d;
  endfunction

  function automatic logic in_pwr(input logic [W-1:0] h);
    return h <= W'(PWR_MAX);
  endfunction

  task automatic check_quiet(input string tag);
    chk(!pkt_vld_o && !err_o, tag, {pkt_vld_o, err_o}, 0);
  endtask

  task automatic check_held(input string tag);
    chk(hdr_o == e_hdr && msg1_o == e_m1 && msg2_o == e_m2 && pwr_ctl_o == e_pwr,
        tag, {hdr_o, msg1_o, msg2_o}, {e_hdr, e_m1, e_m2});
    chk(err_cause_o == e_cause && err_field_o == e_field, tag,
        {err_cause_o, err_field_o}, {e_cause, e_field});
  endtask

  task automatic check_err(input logic [1:0] cause, input logic [1:0] fld, input string tag);
    chk(err_o && !pkt_vld_o && err_cause_o == cause && err_field_o == fld, tag,
        {err_o, err_cause_o, err_field_o}, {1'b1, cause, fld});
    e_cause = cause;
    e_field = fld;
  endtask

  task automatic preamble();
    pre_found_i = 1'b1;
    @(negedge clk);
    pre_found_i = 1'b0;
  endtask

  task automatic strobe(input logic [W-1:0] d, input logic p);
    byte_vld_i = 1'b1;
    byte_i = d;
    par_i = p;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  // bad_par / to_field: field index 0..3, or 4 for none
  task automatic send_pkt(input logic [W-1:0] h, input logic [W-1:0] m1, input logic [W-1:0] m2,
                          input logic [W-1:0] ck, input int bad_par, input int to_field,
                          input int gap);
    logic [W-1:0] f [4];
    f[0] = h; f[1] = m1; f[2] = m2; f[3] = ck;
    preamble();
    for (int i = 0; i < 4; i++) begin
      if (to_field == i) begin
        repeat (GAP) @(negedge clk);
        check_quiet("R5 gap at limit");
        @(negedge clk);
        check_err(2'd3, 2'(i), "R5 gap timeout");
        return;
      end
      repeat (gap) @(negedge clk);
      strobe(f[i], (bad_par == i) ? ~odd_par(f[i]) : odd_par(f[i]));
      if (bad_par == i) begin
        check_err(2'd1, 2'(i), "R3 parity error");
        check_held("R7 data held on error");
        return;
      end
      if (i < 3) check_quiet("R3 no pulse mid packet");
    end
    if (ck == (h ^ m1 ^ m2)) begin
      e_hdr = h; e_m1 = m1; e_m2 = m2; e_pwr = in_pwr(h);
      chk(pkt_vld_o && !err_o, "R2 valid pulse", pkt_vld_o, 1);
      check_held("R2 R8 fields and power flag");
      @(negedge clk);
      chk(!pkt_vld_o, "R11 valid one cycle", pkt_vld_o, 0);
    end else begin
      check_err(2'd2, 2'd3, "R4 checksum mismatch");
      check_held("R7 data held on mismatch");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check_held("R1 reset outputs");
    check_quiet("R1 reset pulses");
    rst_ni = 1'b1;
    @(negedge clk);

    // R10: strobes before any preamble
    strobe(8'h05, odd_par(8'h05));
    strobe(8'h00, odd_par(8'h00));
    check_quiet("R10 strobe while waiting");
    check_held("R10 outputs unchanged");

    // directed good packets around the power range boundary
    send_pkt(8'h0F, 8'h12, 8'h34, 8'h0F ^ 8'h12 ^ 8'h34, 4, 4, 0);
    send_pkt(8'h10, 8'hA5, 8'h5A, 8'h10 ^ 8'hA5 ^ 8'h5A, 4, 4, GAP);
    send_pkt(8'h00, 8'h00, 8'h00, 8'h00, 4, 4, 1);

    // parity on checksum wins over mismatch
    send_pkt(8'h01, 8'h02, 8'h03, 8'hFF, 3, 4, 0);

    // R6: strobes after error, no preamble
    strobe(8'h03, odd_par(8'h03));
    strobe(8'h00, odd_par(8'h00));
    check_quiet("R6 ignored after error");
    check_held("R6 outputs unchanged");

    // R9: preamble mid packet
    preamble();
    strobe(8'h77, odd_par(8'h77));
    strobe(8'h88, odd_par(8'h88));
    send_pkt(8'h09, 8'hC3, 8'h3C, 8'h09 ^ 8'hC3 ^ 8'h3C, 4, 4, 0);
    chk(hdr_o == 8'h09, "R9 restart header", hdr_o, 8'h09);

    // timeout on header and checksum
    send_pkt(8'h01, 8'h02, 8'h03, 8'h00, 4, 0, 0);
    send_pkt(8'h01, 8'h02, 8'h03, 8'h00, 4, 3, 0);

    // random mix
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] h, m1, m2, ck;
      int kind, fld, gap;
      h  = W'($urandom_range(0, 255) >> (($urandom_range(0, 1) == 1) ? 4 : 0));
      m1 = W'($urandom);
      m2 = W'($urandom);
      ck = h ^ m1 ^ m2;
      kind = $urandom_range(0, 3);
      fld  = $urandom_range(0, 3);
      gap  = $urandom_range(0, GAP);
      case (kind)
        0: send_pkt(h, m1, m2, ck, 4, 4, gap);
        1: send_pkt(h, m1, m2, ck, fld, 4, gap);
        2: send_pkt(h, m1, m2, ck ^ W'($urandom_range(1, 255)), 4, 4, gap);
        default: send_pkt(h, m1, m2, ck, 4, fld, gap);
      endcase
      @(negedge clk);
      check_held("R7 hold between packets");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule